// File: doc/BRIEF.md
# Page-Table Address Translator

This block turns a virtual address into a physical address by fetching one entry from a single-level page table kept in physical memory. A requester presents a virtual address, the kind of access (data read, data write or instruction fetch) and the base address of the current process's table. The block forms the entry address, reads the 32-bit entry over a memory read port with a valid/ready request channel, and then checks the entry's valid bit and access rights. It returns either the physical address or a fault code. Pages are 4 KiB, so the low 12 bits of the address pass through unchanged. The default shape has 32 virtual pages (17-bit virtual address) and 8 physical pages (15-bit physical address).

The block works on one translation at a time. It is a four-state machine:
- `ST_IDLE` accepts a request (transition *accept*).
- `ST_ISSUE` holds the memory read request until the port takes it (transition *granted*).
- `ST_WAIT` waits for the read data, then evaluates the entry (transition *entry_back*).
- `ST_DONE` presents the result for one cycle and returns to `ST_IDLE` (transition *retire*).

The table base is sampled when the request is accepted. Each process can therefore use its own table, and the requester switches tables by presenting another base.

Top module: `ptw_translator`

## Requirements
- R1: After reset `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: The read address is the table base sampled at acceptance plus 4 times the virtual page number, which is `req_vaddr[16:12]`. A change of `req_ptbr` after acceptance has no effect on it.
- R3: Once `mem_req_valid` rises, it stays high with a stable `mem_req_addr` until a cycle in which `mem_req_ready` is 1. From acceptance until the result cycle, `req_ready` is 0 and at most one read is outstanding.
- R4: The entry layout is: bit 31 is the valid flag, bits 30:29 are the rights, and bits 2:0 are the physical page number. Bits 28:3 are ignored.
- R5: If the valid flag is 0, `rsp_fault` is 01 (page fault) and `rsp_paddr` is 0, whatever the rights and access kind.
- R6: Rights 00 (read-only) allow a read (`req_kind` 00) and give fault 10 (protection) for a write (01) or a fetch (10).
- R7: Rights 01 (read/write) allow reads and writes and give fault 10 for a fetch.
- R8: Rights 10 (execute) allow only a fetch. Rights 11, and access kind 11, always give fault 10 on a valid entry.
- R9: A permitted access returns `rsp_fault` 00 and `rsp_paddr` equal to the entry's page number joined to `req_vaddr[11:0]`.
- R10: `rsp_valid` is high for exactly one cycle, in the cycle after the read data arrives. In the next cycle `req_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 17 | Virtual address |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 reserved |
| req_ptbr | input | 32 | Page-table base of the current process |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Entry word |
| rsp_valid | output | 1 | Result valid (one cycle) |
| rsp_paddr | output | 15 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 00 none, 01 page fault, 10 protection fault |

## Verification
The hardest situation to reach is a read request that stalls in `ST_ISSUE` for several cycles while the requester changes the base input and the memory answers late. Only this case shows whether the address is held and whether the base is sampled at the right moment. The stimulus draws the memory-ready decision at random each cycle and the response delay at random. It also scrambles `req_ptbr` right after acceptance. Directed cases sweep every combination of rights and access kind over entries whose ignored bits are filled with random values, and random traffic alternates between two processes' tables.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_PAGE = 2'b01,
        FLT_PROT = 2'b10
    } fault_e;

    typedef enum logic [1:0] {
        RGT_RO   = 2'b00,
        RGT_RW   = 2'b01,
        RGT_EXEC = 2'b10,
        RGT_RSVD = 2'b11
    } rights_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ISSUE = 2'b01,
        ST_WAIT  = 2'b10,
        ST_DONE  = 2'b11
    } ptw_state_e;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int ADDR_W    = 32,
    parameter int VPN_W     = 5,
    parameter int PTE_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VPN_W-1:0]  vpn,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int SHIFT = $clog2(PTE_BYTES);

    always_comb begin
        entry_addr = base + (ADDR_W'(vpn) << SHIFT);
    end
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
(
    input  logic       pte_valid,
    input  logic [1:0] rights,
    input  logic [1:0] kind,
    output logic [1:0] fault
);
    logic allowed;

    always_comb begin
        unique case (rights_e'(rights))
            RGT_RO:   allowed = (acc_e'(kind) == ACC_READ);
            RGT_RW:   allowed = (acc_e'(kind) == ACC_READ) || (acc_e'(kind) == ACC_WRITE);
            RGT_EXEC: allowed = (acc_e'(kind) == ACC_FETCH);
            default:  allowed = 1'b0;
        endcase
        if (!pte_valid)
            fault = FLT_PAGE;
        else if (!allowed)
            fault = FLT_PROT;
        else
            fault = FLT_NONE;
    end
endmodule

// File: rtl/ptw_translator.sv
module ptw_translator
    import ptw_pkg::*;
#(
    parameter int VA_W   = 17,
    parameter int PA_W   = 15,
    parameter int OFF_W  = 12,
    parameter int ADDR_W = 32,
    parameter int PTE_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_ptbr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_fault
);
    localparam int VPN_W   = VA_W - OFF_W;
    localparam int PPN_W   = PA_W - OFF_W;
    localparam int VLD_BIT = PTE_W - 1;
    localparam int RGT_HI  = PTE_W - 2;
    localparam int RGT_LO  = PTE_W - 3;

    ptw_state_e state_q, state_d;

    logic [ADDR_W-1:0] entry_addr_c;
    logic [ADDR_W-1:0] addr_q;
    logic [OFF_W-1:0]  off_q;
    logic [1:0]        kind_q;
    logic [1:0]        fault_c;
    logic [1:0]        fault_q;
    logic [PA_W-1:0]   paddr_q;
    logic              unused_pte_bits;

    assign unused_pte_bits = ^mem_rsp_data[RGT_LO-1:PPN_W];

    ptw_entry_addr #(
        .ADDR_W   (ADDR_W),
        .VPN_W    (VPN_W),
        .PTE_BYTES(PTE_W / 8)
    ) u_addr (
        .base      (req_ptbr),
        .vpn       (req_vaddr[VA_W-1:OFF_W]),
        .entry_addr(entry_addr_c)
    );

    ptw_perm_check u_perm (
        .pte_valid(mem_rsp_data[VLD_BIT]),
        .rights   (mem_rsp_data[RGT_HI:RGT_LO]),
        .kind     (kind_q),
        .fault    (fault_c)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: accept, granted, entry_back, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)     state_d = ST_ISSUE;
            ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:                     state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_ISSUE);
        rsp_valid     = (state_q == ST_DONE);
        mem_req_addr  = addr_q;
        rsp_paddr     = paddr_q;
        rsp_fault     = fault_q;
    end

    // datapath captures
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            off_q   <= '0;
            kind_q  <= '0;
            fault_q <= FLT_NONE;
            paddr_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                addr_q <= entry_addr_c;
                off_q  <= req_vaddr[OFF_W-1:0];
                kind_q <= req_kind;
            end
            if (state_q == ST_WAIT && mem_rsp_valid) begin
                fault_q <= fault_c;
                if (fault_c == FLT_NONE)
                    paddr_q <= {mem_rsp_data[PPN_W-1:0], off_q};
                else
                    paddr_q <= '0;
            end
        end
    end

    assert_issue_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_accept_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_req_valid && !req_ready));

    assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && mem_rsp_valid) |=> rsp_valid);

    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    assert_page_no_pa_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_PAGE) |-> (rsp_paddr == '0));

    assert_fault_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault != 2'b11));
endmodule

// File: tb/ptw_translator_tb.sv
module ptw_translator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [16:0] req_vaddr;
    logic [1:0]  req_kind;
    logic [31:0] req_ptbr;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        rsp_valid;
    logic [14:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] tbl  [2][32];
    logic [31:0] bases[2];

    always #2 clk = ~clk;

    ptw_translator dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_ptbr(req_ptbr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_fault(input logic [31:0] pte, input logic [1:0] kind);
        bit ok;
        if (!pte[31]) return 2'b01;
        case (pte[30:29])
            2'b00:   ok = (kind == 2'b00);
            2'b01:   ok = (kind == 2'b00) || (kind == 2'b01);
            2'b10:   ok = (kind == 2'b10);
            default: ok = 1'b0;
        endcase
        return ok ? 2'b00 : 2'b10;
    endfunction

    function automatic logic [31:0] make_pte(input bit v, input logic [1:0] r, input logic [2:0] ppn);
        logic [31:0] junk;
        junk = $urandom;
        return {v, r, junk[25:0], ppn};
    endfunction

    task automatic xlate(input int p, input logic [16:0] va, input logic [1:0] kind, input int lat);
        logic [31:0] pte;
        logic [31:0] exp_addr;
        logic [1:0]  ef;
        logic [14:0] ep;
        string       tag;
        bit          go;
        pte      = tbl[p][va[16:12]];
        exp_addr = bases[p] + {25'd0, va[16:12], 2'b00};
        ef       = exp_fault(pte, kind);
        ep       = (ef == 2'b00) ? {pte[2:0], va[11:0]} : 15'd0;
        tag      = !pte[31] ? "R5" : (pte[30:29] == 2'b00) ? "R6" :
                   (pte[30:29] == 2'b01) ? "R7" : "R8";
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_ptbr = bases[p];
        @(negedge clk);
        req_valid = 1'b0; req_ptbr = $urandom; req_vaddr = $urandom; req_kind = $urandom;
        for (int g = 0; g < 50; g++) begin
            chk(mem_req_valid == 1'b1, "R3 request held", {31'd0, mem_req_valid}, 32'd1);
            chk(mem_req_addr == exp_addr, "R2 entry address", mem_req_addr, exp_addr);
            chk(req_ready == 1'b0, "R3 busy", {31'd0, req_ready}, 32'd0);
            go = (g > 6) || (($urandom % 3) != 0);
            mem_req_ready = go;
            @(negedge clk);
            if (go) break;
        end
        mem_req_ready = 1'b0;
        for (int k = 0; k < lat; k++) begin
            chk(rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R3 one outstanding",
                {30'd0, rsp_valid, mem_req_valid}, 32'd0);
            @(negedge clk);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = pte;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = $urandom;
        chk(rsp_valid == 1'b1, "R10 result cycle", {31'd0, rsp_valid}, 32'd1);
        chk(rsp_fault == ef, tag, {30'd0, rsp_fault}, {30'd0, ef});
        chk(rsp_paddr == ep, (ef == 2'b00) ? "R9 paddr" : "R5 paddr zero",
            {17'd0, rsp_paddr}, {17'd0, ep});
        @(negedge clk);
        chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R10 pulse end",
            {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2468));
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0; req_ptbr = '0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        bases[0] = 32'h0000_4000;
        bases[1] = 32'h0001_7F00;
        for (int p = 0; p < 2; p++)
            for (int v = 0; v < 32; v++)
                tbl[p][v] = make_pte(($urandom % 4) != 0, 2'($urandom), 3'($urandom));
        // directed entries in process 0 (R4: random ignored bits in each)
        tbl[0][0]  = make_pte(1'b1, 2'b00, 3'd5);
        tbl[0][1]  = make_pte(1'b1, 2'b01, 3'd2);
        tbl[0][2]  = make_pte(1'b1, 2'b10, 3'd7);
        tbl[0][3]  = make_pte(1'b1, 2'b11, 3'd1);
        tbl[0][4]  = make_pte(1'b0, 2'b01, 3'd6);
        tbl[0][31] = make_pte(1'b1, 2'b01, 3'd7);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", {31'd0, req_ready}, 32'd1);
        chk(mem_req_valid == 1'b0, "R1 no read", {31'd0, mem_req_valid}, 32'd0);
        chk(rsp_valid == 1'b0, "R1 no result", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        // every rights x kind combination, plus invalid entry
        for (int v = 0; v < 5; v++)
            for (int k = 0; k < 4; k++)
                xlate(0, {5'(v), 12'($urandom)}, 2'(k), k);
        // offset boundaries and last page (R9)
        xlate(0, {5'd31, 12'h000}, 2'b01, 0);
        xlate(0, {5'd31, 12'hFFF}, 2'b00, 3);
        xlate(0, {5'd0, 12'hFFF}, 2'b00, 1);
        // random traffic over two tables (R2 base switch, R4 ignored bits)
        for (int i = 0; i < 300; i++)
            xlate(int'($urandom % 2), 17'($urandom), 2'($urandom), int'($urandom % 4));
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule